// File: doc/BRIEF.md
# I2C Slave Read Engine with Clock Stretching

This block is the bit and byte engine of an I2C target that answers read transfers. It watches synchronized copies of the clock and data lines, finds START and STOP conditions, and shifts in the address byte(s). Matching works against a 10-bit programmable address in either 7-bit or 10-bit format. On a match it pulls the data line low for the acknowledge slot and records the direction bit. Both bus lines are driven only low, through the `sclDriveLow` and `sdaDriveLow` outputs, which the pad logic turns into open-drain pulls.

When a read is addressed to it, the engine raises `readReq` and holds the clock line low for as long as it takes the local software to present a byte on `txByte` with a one-cycle `txValid` strobe. The byte then goes out MSB first. After each byte the engine looks at the acknowledge bit from the controller. An ACK starts a new request and a new stretch. A NACK sends the engine back to idle until the next START or STOP. Write-direction transfers are acknowledged at the address level only.

The address and format select are captured only while the engine is disabled. A configuration that asks for controller and target operation at the same time keeps the engine disabled.

Top module: `i2c_read_slave`

## Requirements
- R1: With `tenBitMode`=0, the first byte after a START whose bits [7:1] equal `ownAddr[6:0]` is acknowledged: SDA is pulled low for the whole ninth clock. A byte with any other address is not acknowledged. Data bytes that follow a write-direction address are not acknowledged either.
- R2: With `tenBitMode`=1, a header byte of the form 1,1,1,1,0,`ownAddr[9]`,`ownAddr[8]`,0 (bit 0 is R/W, 1 means read) is acknowledged, and so is a following byte equal to `ownAddr[7:0]`. A 7-bit style byte equal to {`ownAddr[6:0]`,0} is not acknowledged, and a following byte other than `ownAddr[7:0]` is not acknowledged.
- R3: In 10-bit mode, a read header (bit 0 = 1) is acknowledged only after a repeated START that follows a fully matched 10-bit write address within the same transaction. Without that, the read header is not acknowledged.
- R4: `ownAddr` and `tenBitMode` are captured only while the engine is disabled. Changing them while enabled has no effect on matching.
- R5: While `masterReq` is 1, the engine stays disabled: it acknowledges nothing and drives neither line.
- R6: After a read-direction match, from the end of the acknowledge clock the engine holds SCL low and keeps `readReq` at 1 until `txValid` is seen.
- R7: `readReq` is 0 in the cycle after the one that samples `txValid`=1. SCL stays held for that one cycle with SDA already carrying the byte's MSB, and is released in the cycle after.
- R8: Bytes go out MSB first, and SDA changes only while SCL is low.
- R9: If the controller ACKs a byte, `readReq` rises again with a new stretch. If it NACKs, SDA and SCL are released and `readReq` stays 0.
- R10: A START restarts address reception from bit 7 in any state, even in the middle of a byte. A STOP releases both lines, and bits clocked after it are ignored until the next START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Synchronized bus clock level |
| sdaIn | input | 1 | Synchronized bus data level |
| sclDriveLow | output | 1 | 1 pulls the clock line low (stretch) |
| sdaDriveLow | output | 1 | 1 pulls the data line low |
| ownAddr | input | 10 | Own target address |
| tenBitMode | input | 1 | 1 selects 10-bit address matching |
| enableReq | input | 1 | Requests target operation |
| masterReq | input | 1 | Controller operation request; blocks enable |
| readReq | output | 1 | Waiting for a byte to transmit |
| txValid | input | 1 | One-cycle strobe: `txByte` is valid |
| txByte | input | 8 | Byte to transmit |

## Verification
The address path is tried with a matching 7-bit write, a wrong 7-bit address, a 7-bit style byte in 10-bit mode, correct and wrong 10-bit low bytes, and a 10-bit read header with and without an earlier write match. Each of these separates one arm of the match decision from the others. A multi-byte read with unequal software delays and mixed master ACK/NACK shows that stretch length follows the software and not a fixed count, and that ACK and NACK lead to different states. A START cut into a half-clocked byte, and bits clocked after a STOP, show whether the bit counter really restarts. Address changes while enabled, and a combined controller/target request, confirm that the configuration path ignores both.

// File: rtl/i2c_rtx_pkg.sv
package i2c_rtx_pkg;
  localparam int ADDR_W = 10;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [4:0] HDR10 = 5'b11110;

  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic sdaLevel;
  } busEv_t;

  typedef struct packed {
    logic clrCnt;
    logic shiftIn;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;

  typedef struct packed {
    logic hit7;
    logic hit10Hdr;
    logic hit10Low;
    logic rwBit;
  } addrHit_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_WAIT, ST_LOAD, ST_TX, ST_MACK, ST_SKIP
  } engState_t;

  typedef enum logic [1:0] {
    AF_SKIP, AF_SECOND, AF_TX
  } afterAck_t;
endpackage

// File: rtl/i2c_rtx_datapath.sv
module i2c_rtx_datapath
  import i2c_rtx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              tenBitMode,
  input  logic              enableReq,
  input  logic              masterReq,
  input  logic [BYTE_W-1:0] txByte,
  input  dpStrobe_t         strobe,
  output busEv_t            busEv,
  output addrHit_t          addrHit,
  output logic              txMsb,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              enActive,
  output logic              cfgTen
);
  logic sclQ, sdaQ;
  logic [ADDR_W-1:0] cfgAddr;
  logic [BYTE_W-1:0] rxShift, txShift;

  // line history for edge and condition detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
    end
  end

  always_comb begin
    busEv.sclRise   = sclIn & ~sclQ;
    busEv.sclFall   = ~sclIn & sclQ;
    busEv.startSeen = sclIn & sclQ & sdaQ & ~sdaIn;
    busEv.stopSeen  = sclIn & sclQ & ~sdaQ & sdaIn;
    busEv.sdaLevel  = sdaIn;
  end

  // enable gating and configuration capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enActive <= 1'b0;
      cfgAddr  <= '0;
      cfgTen   <= 1'b0;
    end else begin
      enActive <= enableReq & ~masterReq;
      if (!enActive) begin
        cfgAddr <= ownAddr;
        cfgTen  <= tenBitMode;
      end
    end
  end

  // shifters and bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '1;
      bitCnt  <= '0;
    end else begin
      if (strobe.shiftIn) rxShift <= {rxShift[BYTE_W-2:0], sdaIn};
      if (strobe.loadTx)
        txShift <= txByte;
      else if (strobe.shiftTx)
        txShift <= {txShift[BYTE_W-2:0], 1'b1};
      if (strobe.clrCnt || strobe.loadTx)
        bitCnt <= '0;
      else if (strobe.shiftIn || strobe.shiftTx)
        bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    addrHit.hit7     = (rxShift[BYTE_W-1:1] == cfgAddr[BYTE_W-2:0]);
    addrHit.hit10Hdr = (rxShift[BYTE_W-1:3] == HDR10) &&
                       (rxShift[2:1] == cfgAddr[ADDR_W-1:BYTE_W]);
    addrHit.hit10Low = (rxShift == cfgAddr[BYTE_W-1:0]);
    addrHit.rwBit    = rxShift[0];
  end

  assign txMsb = txShift[BYTE_W-1];

  assert_cfg_frozen_R4: assert property (@(posedge clk) disable iff (!rstN)
    (enActive && $past(enActive)) |-> ($stable(cfgAddr) && $stable(cfgTen)));

  assert_master_blocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    masterReq |=> !enActive);

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(BYTE_W));
endmodule

// File: rtl/i2c_rtx_ctrl.sv
module i2c_rtx_ctrl
  import i2c_rtx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  busEv_t           busEv,
  input  addrHit_t         addrHit,
  input  logic             txMsb,
  input  logic [CNT_W-1:0] bitCnt,
  input  logic             enActive,
  input  logic             cfgTen,
  input  logic             txValid,
  output dpStrobe_t        strobe,
  output logic             sclDriveLow,
  output logic             sdaDriveLow,
  output logic             readReq
);
  engState_t state, stateNxt;
  afterAck_t afterAck, afterNxt, kind;
  logic secondByte, secondNxt;
  logic tenMatched, tenNxt;
  logic slotRise, slotNxt;
  logic masterAck, mackNxt;
  logic ackIt;

  always_comb begin
    stateNxt  = state;
    afterNxt  = afterAck;
    secondNxt = secondByte;
    tenNxt    = tenMatched;
    slotNxt   = slotRise;
    mackNxt   = masterAck;
    strobe    = '0;
    ackIt     = 1'b0;
    kind      = AF_SKIP;
    if (!enActive) begin
      stateNxt  = ST_IDLE;
      tenNxt    = 1'b0;
      secondNxt = 1'b0;
    end else if (busEv.stopSeen) begin
      stateNxt = ST_IDLE;
      tenNxt   = 1'b0;
    end else if (busEv.startSeen) begin
      stateNxt      = ST_RX;
      secondNxt     = 1'b0;
      strobe.clrCnt = 1'b1;
    end else begin
      unique case (state)
        ST_RX: begin
          if (busEv.sclRise && bitCnt != CNT_W'(BYTE_W)) begin
            strobe.shiftIn = 1'b1;
          end else if (busEv.sclFall && bitCnt == CNT_W'(BYTE_W)) begin
            if (secondByte) begin
              if (addrHit.hit10Low) begin
                ackIt  = 1'b1;
                tenNxt = 1'b1;
              end
            end else if (!cfgTen) begin
              if (addrHit.hit7) begin
                ackIt = 1'b1;
                kind  = addrHit.rwBit ? AF_TX : AF_SKIP;
              end
            end else if (addrHit.hit10Hdr && !addrHit.rwBit) begin
              ackIt  = 1'b1;
              kind   = AF_SECOND;
              tenNxt = 1'b0;
            end else if (addrHit.hit10Hdr && tenMatched) begin
              ackIt = 1'b1;
              kind  = AF_TX;
            end
            stateNxt = ackIt ? ST_ACK : ST_SKIP;
            afterNxt = kind;
            slotNxt  = 1'b0;
          end
        end
        ST_ACK: begin
          if (busEv.sclRise) begin
            slotNxt = 1'b1;
          end else if (busEv.sclFall && slotRise) begin
            unique case (afterAck)
              AF_TX:     stateNxt = ST_WAIT;
              AF_SECOND: begin
                stateNxt      = ST_RX;
                secondNxt     = 1'b1;
                strobe.clrCnt = 1'b1;
              end
              default:   stateNxt = ST_SKIP;
            endcase
          end
        end
        ST_WAIT: begin
          if (txValid) begin
            strobe.loadTx = 1'b1;
            stateNxt      = ST_LOAD;
          end
        end
        ST_LOAD: stateNxt = ST_TX;
        ST_TX: begin
          if (busEv.sclFall) begin
            if (bitCnt == CNT_W'(BYTE_W - 1)) begin
              stateNxt = ST_MACK;
              slotNxt  = 1'b0;
            end else begin
              strobe.shiftTx = 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (busEv.sclRise) begin
            slotNxt = 1'b1;
            mackNxt = ~busEv.sdaLevel;
          end else if (busEv.sclFall && slotRise) begin
            stateNxt = masterAck ? ST_WAIT : ST_SKIP;
          end
        end
        default: stateNxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      afterAck   <= AF_SKIP;
      secondByte <= 1'b0;
      tenMatched <= 1'b0;
      slotRise   <= 1'b0;
      masterAck  <= 1'b0;
    end else begin
      state      <= stateNxt;
      afterAck   <= afterNxt;
      secondByte <= secondNxt;
      tenMatched <= tenNxt;
      slotRise   <= slotNxt;
      masterAck  <= mackNxt;
    end
  end

  assign readReq     = (state == ST_WAIT);
  assign sclDriveLow = (state == ST_WAIT) || (state == ST_LOAD);
  assign sdaDriveLow = (state == ST_ACK) ||
                       (((state == ST_LOAD) || (state == ST_TX)) && !txMsb);

  assert_req_clears_R7: assert property (@(posedge clk) disable iff (!rstN || !enActive)
    (readReq && txValid) |=> (!readReq && sclDriveLow));

  assert_scl_release_R7: assert property (@(posedge clk) disable iff (!rstN || !enActive)
    (readReq && txValid) |=> ##1 !sclDriveLow);

  assert_sda_moves_low_R8: assert property (@(posedge clk) disable iff (!rstN || !enActive)
    !$stable(sdaDriveLow) |-> !sclIn);

  assert_req_after_slot_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readReq) |-> $past((state == ST_ACK) || (state == ST_MACK)));

  assert_quiet_disabled_R5: assert property (@(posedge clk) disable iff (!rstN)
    !enActive |=> (!sclDriveLow && !sdaDriveLow));
endmodule

// File: rtl/i2c_read_slave.sv
module i2c_read_slave
  import i2c_rtx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              tenBitMode,
  input  logic              enableReq,
  input  logic              masterReq,
  output logic              readReq,
  input  logic              txValid,
  input  logic [BYTE_W-1:0] txByte
);
  busEv_t           busEv;
  addrHit_t         addrHit;
  dpStrobe_t        strobe;
  logic             txMsb;
  logic [CNT_W-1:0] bitCnt;
  logic             enActive;
  logic             cfgTen;

  i2c_rtx_datapath u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .ownAddr(ownAddr), .tenBitMode(tenBitMode),
    .enableReq(enableReq), .masterReq(masterReq), .txByte(txByte),
    .strobe(strobe), .busEv(busEv), .addrHit(addrHit), .txMsb(txMsb),
    .bitCnt(bitCnt), .enActive(enActive), .cfgTen(cfgTen)
  );

  i2c_rtx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .busEv(busEv),
    .addrHit(addrHit), .txMsb(txMsb), .bitCnt(bitCnt),
    .enActive(enActive), .cfgTen(cfgTen), .txValid(txValid),
    .strobe(strobe), .sclDriveLow(sclDriveLow),
    .sdaDriveLow(sdaDriveLow), .readReq(readReq)
  );
endmodule

// File: tb/i2c_read_slave_bench.sv
module i2c_read_slave_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sclLine, sdaLine;
  logic sclDriveLow, sdaDriveLow, readReq;
  logic [9:0] ownAddr = 10'h05A;
  logic tenBitMode = 1'b0, enableReq = 1'b0, masterReq = 1'b0;
  logic txValid = 1'b0;
  logic [7:0] txByte = 8'h00;
  int total = 0, bad = 0, sdaViol = 0;
  bit done = 1'b0;
  logic [7:0] expQ[$];
  logic [7:0] obsQ[$];
  logic sdaPrev = 1'b0;

  always #5 clk = ~clk;
  assign sclLine = mScl & ~sclDriveLow;
  assign sdaLine = mSda & ~sdaDriveLow;

  i2c_read_slave u_i2c_read_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .ownAddr(ownAddr), .tenBitMode(tenBitMode), .enableReq(enableReq),
    .masterReq(masterReq), .readReq(readReq), .txValid(txValid),
    .txByte(txByte)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clockBit(input bit v, output bit s);
    mSda = v;
    waitClk(3);
    mScl = 1'b1;
    while (sclLine !== 1'b1) @(negedge clk);
    waitClk(3);
    s = sdaLine;
    waitClk(3);
    mScl = 1'b0;
    waitClk(2);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s);
    clockBit(1'b1, s);
    acked = (s == 1'b0);
  endtask

  task automatic readByte(input bit giveAck, output logic [7:0] b);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s);
      b[i] = s;
    end
    clockBit(!giveAck, s);
    obsQ.push_back(b);
  endtask

  task automatic mStart;
    mSda = 1'b1;
    waitClk(2);
    mScl = 1'b1;
    while (sclLine !== 1'b1) @(negedge clk);
    waitClk(3);
    mSda = 1'b0;
    waitClk(3);
    mScl = 1'b0;
    waitClk(3);
  endtask

  task automatic mStop;
    mSda = 1'b0;
    waitClk(2);
    mScl = 1'b1;
    while (sclLine !== 1'b1) @(negedge clk);
    waitClk(3);
    mSda = 1'b1;
    waitClk(3);
  endtask

  task automatic supplyByte(input logic [7:0] b, input int hold);
    while (readReq !== 1'b1) @(negedge clk);
    waitClk(hold);
    check(sclLine == 1'b0 && readReq == 1'b1, "R6 stretch held while waiting",
          32'({sclLine, readReq}), 32'h1);
    expQ.push_back(b);
    txByte = b;
    txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
    check(readReq == 1'b0 && sclDriveLow == 1'b1 && sdaDriveLow == ~b[7],
          "R7 request cleared, MSB set under stretch",
          32'({readReq, sclDriveLow, sdaDriveLow}), 32'({1'b0, 1'b1, ~b[7]}));
    @(negedge clk);
    check(sclDriveLow == 1'b0, "R7 clock released", 32'(sclDriveLow), 32'h0);
  endtask

  task automatic configure(input logic [9:0] a, input bit ten, input bit en, input bit mst);
    enableReq = 1'b0;
    masterReq = 1'b0;
    waitClk(3);
    ownAddr = a;
    tenBitMode = ten;
    waitClk(3);
    masterReq = mst;
    enableReq = en;
    waitClk(3);
  endtask

  // scoreboard monitor: compare each byte the master read with the byte supplied
  always @(negedge clk) begin
    logic [7:0] got, want;
    if (obsQ.size() > 0) begin
      got = obsQ.pop_front();
      if (expQ.size() == 0) begin
        check(1'b0, "R8 byte read with no byte supplied", 32'(got), 32'h0);
      end else begin
        want = expQ.pop_front();
        check(got == want, "R8 byte order MSB first", 32'(got), 32'(want));
      end
    end
  end

  // SDA must only move while SCL is low (R8)
  always @(posedge clk) begin
    if (rstN && (sdaDriveLow !== sdaPrev) && sclLine) sdaViol++;
    sdaPrev <= sdaDriveLow;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] rb;
    waitClk(5);
    rstN = 1'b1;
    waitClk(2);
    check(readReq == 1'b0 && sclDriveLow == 1'b0 && sdaDriveLow == 1'b0,
          "R10 reset state released", 32'({readReq, sclDriveLow, sdaDriveLow}), 32'h0);

    configure(10'h05A, 1'b0, 1'b1, 1'b0);

    // R1: matching 7-bit write, then a data byte
    mStart;
    sendByte({7'h5A, 1'b0}, ack);
    check(ack == 1'b1, "R1 7-bit write address acked", 32'(ack), 32'h1);
    sendByte(8'h33, ack);
    check(ack == 1'b0, "R1 write data not acked", 32'(ack), 32'h0);
    mStop;

    // R1: wrong 7-bit address
    mStart;
    sendByte({7'h3C, 1'b0}, ack);
    check(ack == 1'b0, "R1 other 7-bit address not acked", 32'(ack), 32'h0);
    mStop;

    // R6 R7 R8 R9: three-byte read, ACK, ACK, NACK
    mStart;
    sendByte({7'h5A, 1'b1}, ack);
    check(ack == 1'b1, "R1 7-bit read address acked", 32'(ack), 32'h1);
    fork
      begin
        supplyByte(8'hA5, 30);
        supplyByte(8'h3C, 12);
        supplyByte(8'h81, 7);
      end
      begin
        readByte(1'b1, rb);
        waitClk(1);
        check(readReq == 1'b1 && sclDriveLow == 1'b1, "R9 ACK brings new request",
              32'({readReq, sclDriveLow}), 32'h3);
        readByte(1'b1, rb);
        readByte(1'b0, rb);
        waitClk(3);
        check(readReq == 1'b0 && sdaDriveLow == 1'b0 && sclDriveLow == 1'b0,
              "R9 NACK releases lines", 32'({readReq, sdaDriveLow, sclDriveLow}), 32'h0);
      end
    join
    mStop;

    // R4: address change while enabled has no effect
    ownAddr = 10'h011;
    waitClk(3);
    mStart;
    sendByte({7'h11, 1'b0}, ack);
    check(ack == 1'b0, "R4 new address ignored while enabled", 32'(ack), 32'h0);
    mStop;
    mStart;
    sendByte({7'h5A, 1'b0}, ack);
    check(ack == 1'b1, "R4 captured address still matches", 32'(ack), 32'h1);
    mStop;

    // R5: controller and target requested together
    configure(10'h05A, 1'b0, 1'b1, 1'b1);
    mStart;
    sendByte({7'h5A, 1'b1}, ack);
    check(ack == 1'b0, "R5 combined request stays disabled", 32'(ack), 32'h0);
    check(readReq == 1'b0 && sclDriveLow == 1'b0, "R5 no stretch when disabled",
          32'({readReq, sclDriveLow}), 32'h0);
    mStop;

    // R2: 10-bit mode, address 0x2C7
    configure(10'h2C7, 1'b1, 1'b1, 1'b0);
    mStart;
    sendByte({7'h47, 1'b0}, ack);
    check(ack == 1'b0, "R2 7-bit style byte ignored in 10-bit mode", 32'(ack), 32'h0);
    mStop;
    mStart;
    sendByte(8'hF4, ack);
    check(ack == 1'b1, "R2 10-bit header acked", 32'(ack), 32'h1);
    sendByte(8'hC7, ack);
    check(ack == 1'b1, "R2 10-bit low byte acked", 32'(ack), 32'h1);
    sendByte(8'h12, ack);
    check(ack == 1'b0, "R1 data after 10-bit write not acked", 32'(ack), 32'h0);
    mStop;
    mStart;
    sendByte(8'hF4, ack);
    sendByte(8'hC8, ack);
    check(ack == 1'b0, "R2 wrong 10-bit low byte not acked", 32'(ack), 32'h0);
    mStop;

    // R3: 10-bit read
    mStart;
    sendByte(8'hF5, ack);
    check(ack == 1'b0, "R3 read header without prior match not acked", 32'(ack), 32'h0);
    mStop;
    mStart;
    sendByte(8'hF4, ack);
    sendByte(8'hC7, ack);
    mStart;
    sendByte(8'hF5, ack);
    check(ack == 1'b1, "R3 read header after repeated START acked", 32'(ack), 32'h1);
    fork
      supplyByte(8'h5E, 9);
      readByte(1'b0, rb);
    join
    mStop;

    // R10: START in the middle of a byte, then STOP and bits without START
    mStart;
    for (int i = 0; i < 4; i++) begin
      bit s;
      clockBit(1'b1, s);
    end
    mStart;
    sendByte(8'hF4, ack);
    check(ack == 1'b1, "R10 START restarts bit count", 32'(ack), 32'h1);
    sendByte(8'hC7, ack);
    mStop;
    waitClk(3);
    check(sclDriveLow == 1'b0 && sdaDriveLow == 1'b0 && readReq == 1'b0,
          "R10 STOP releases lines", 32'({sclDriveLow, sdaDriveLow, readReq}), 32'h0);
    mScl = 1'b0;
    waitClk(3);
    sendByte(8'hF4, ack);
    check(ack == 1'b0, "R10 bits after STOP ignored", 32'(ack), 32'h0);
    mStop;

    waitClk(5);
    check(sdaViol == 0, "R8 SDA moved only with SCL low", 32'(sdaViol), 32'h0);
    check(expQ.size() == 0 && obsQ.size() == 0, "R8 all supplied bytes read",
          32'(expQ.size() + obsQ.size()), 32'h0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule